// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block presents interrupts to one processor. It holds at most one pending interrupt and drives a single interrupt line toward the CPU. Register-style commands act on its state. One command sets the processor's current priority threshold. Another sets the priority of an inter-processor interrupt (IPI) request. The others accept the pending interrupt, end an interrupt, or read the state without changing it. Smaller priority numbers are more favored, and 8'hff means no priority.

A source controller offers interrupts over a valid/ready channel, each with a source number and a priority. The unit either takes the offer or returns the number on its reject channel. A pending source interrupt that a better candidate displaces is also returned as a reject. The unit signals end-of-interrupt and resend requests back toward the source side.

Every command completes in a single clock cycle. All responses appear as one-cycle pulses on the following clock.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the current priority and pending source number are 0, the pending priority and the IPI priority are 8'hff, the interrupt line is low and every pulse output is low.
- R2: An offer is rejected when its priority is greater than or equal to the current priority. It is also rejected when an interrupt is already pending at a priority less than or equal to the offer's. A rejected offer pulses `rej_valid` with `rej_src` equal to the offered number.
- R3: An offer that is not rejected becomes pending and raises `irq_out`. Any pending source interrupt it replaces is returned on the reject channel in the same response cycle.
- R4: A command with `cmd_op`=3 loads the IPI priority from `cmd_data[7:0]`. When that value is below the current priority, the unit runs an IPI check. The check changes nothing if an interrupt is pending at a priority less than or equal to the new value. Otherwise the pending number becomes `IPI_SRC`, the pending priority becomes the new value, and `irq_out` rises.
- R5: A command with `cmd_op`=2 loads the current priority from `cmd_data[7:0]`. When the new value is smaller than the old one and an interrupt is pending at a priority greater than or equal to the new value, the pending interrupt is dropped. Dropping it lowers `irq_out` and returns the dropped source on the reject channel.
- R6: When a `cmd_op`=2 write is not smaller than the old value and nothing is pending, it pulses `resend_req`. While an interrupt is pending, the same write gives no resend.
- R7: A command with `cmd_op`=1 (accept) does three things. It returns `{current priority, pending number}` on `rsp_data`, with the pending number in bits 23:0. It moves the pending priority into the current priority. It clears the pending number, sets the pending priority to 8'hff and lowers `irq_out`.
- R8: A command with `cmd_op`=4 (end of interrupt) copies `cmd_data[31:24]` into the current priority. It pulses `eoi_valid` with `eoi_src` equal to `cmd_data[23:0]`. When nothing is pending, it also runs a resend.
- R9: A resend pulses `resend_req`. When the IPI priority is below the resulting current priority, the resend first makes the IPI pending at that priority.
- R10: A command with `cmd_op`=0 (poll) returns the same word as an accept, together with the IPI priority on `rsp_mfrr`, and changes no state.
- R11: A displaced or dropped IPI is never sent on the reject channel. Source numbers offered are never 0 and never `IPI_SRC`.
- R12: `ofr_ready` is low whenever `cmd_valid` is high, and an offer is consumed only when `ofr_valid` and `ofr_ready` are both high. `irq_out` is high exactly when a pending number is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, always taken |
| cmd_op | input | 3 | 0 poll, 1 accept, 2 set priority, 3 set IPI priority, 4 end of interrupt |
| cmd_data | input | 32 | Command operand |
| ofr_valid | input | 1 | Offer from source side is valid |
| ofr_ready | output | 1 | Offer can be consumed this cycle |
| ofr_src | input | 24 | Offered source number |
| ofr_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the CPU |
| rej_valid | output | 1 | Reject pulse toward the source side |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request pulse |
| eoi_valid | output | 1 | End-of-interrupt pulse toward the source side |
| eoi_src | output | 24 | Source number being ended |
| rsp_valid | output | 1 | Poll/accept response pulse |
| rsp_data | output | 32 | Current priority (31:24) and pending number (23:0) |
| rsp_mfrr | output | 8 | IPI priority at response time |

## Verification
Every cycle, the checker confirms several invariants. The interrupt line follows the held pending number. An empty slot carries priority 8'hff. Accept always empties the slot. Poll leaves all state untouched. End of interrupt forwards its number. No reject ever carries the IPI number. Only the bench's scenarios can show the ordering decisions: which offer wins against a pending one, the IPI check's tie rule, the condition for a threshold write to drop the pending interrupt, and the IPI that a resend injects after end of interrupt. These depend on command sequences with known expected words.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_POLL   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_CPPR   = 3'd2,
    OP_MFRR   = 3'd3,
    OP_EOI    = 3'd4
  } ipc_op_e;
endpackage

// File: rtl/ipc_offer_judge.sv
// Decides whether an incoming offer beats both the threshold and the held one.
module ipc_offer_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              held_any,
  input  logic [PRIO_W-1:0] held_prio,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              take
);
  always_comb begin
    take = (offer_prio < cur_prio) && !(held_any && (held_prio <= offer_prio));
  end
endmodule

// File: rtl/ipc_ipi_judge.sv
// Decides whether an IPI at the given priority may replace the held slot.
module ipc_ipi_judge #(
  parameter int PRIO_W = 8
) (
  input  logic              held_any,
  input  logic [PRIO_W-1:0] held_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              take
);
  always_comb begin
    take = !held_any || (held_prio > ipi_prio);
  end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]   cmd_data,
  input  logic                      ofr_valid,
  output logic                      ofr_ready,
  input  logic [SRC_W-1:0]          ofr_src,
  input  logic [PRIO_W-1:0]         ofr_prio,
  output logic                      irq_out,
  output logic                      rej_valid,
  output logic [SRC_W-1:0]          rej_src,
  output logic                      resend_req,
  output logic                      eoi_valid,
  output logic [SRC_W-1:0]          eoi_src,
  output logic                      rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]   rsp_data,
  output logic [PRIO_W-1:0]         rsp_mfrr
);
  import ipc_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr_q, pprio_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic [PRIO_W-1:0] cppr_n, pprio_n, mfrr_n;
  logic [SRC_W-1:0]  xisr_n;

  logic              irq_q, rej_q, resend_q, eoi_q, rsp_q;
  logic [SRC_W-1:0]  rej_src_q, eoi_src_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic [PRIO_W-1:0] rsp_mfrr_q;
  logic              rej_n, resend_n, eoi_n, rsp_n;
  logic [SRC_W-1:0]  rej_src_n, eoi_src_n;
  logic [WORD_W-1:0] rsp_data_n;
  logic [PRIO_W-1:0] rsp_mfrr_n;

  logic              held_any, bounce, ofr_take, ipi_take, mfrr_cmd;
  logic [PRIO_W-1:0] op_prio, eoi_prio, ipi_level;
  ipc_op_e           op;

  assign op        = ipc_op_e'(cmd_op);
  assign held_any  = (xisr_q != '0);
  assign bounce    = held_any && (xisr_q != IPI_NUM);
  assign op_prio   = cmd_data[PRIO_W-1:0];
  assign eoi_prio  = cmd_data[WORD_W-1:SRC_W];
  assign mfrr_cmd  = cmd_valid && (op == OP_MFRR);
  assign ipi_level = mfrr_cmd ? op_prio : mfrr_q;
  assign ofr_ready = !cmd_valid;

  ipc_offer_judge #(.PRIO_W(PRIO_W)) u_offer (
    .cur_prio  (cppr_q),
    .held_any  (held_any),
    .held_prio (pprio_q),
    .offer_prio(ofr_prio),
    .take      (ofr_take)
  );

  ipc_ipi_judge #(.PRIO_W(PRIO_W)) u_ipi (
    .held_any (held_any),
    .held_prio(pprio_q),
    .ipi_prio (ipi_level),
    .take     (ipi_take)
  );

  always_comb begin
    cppr_n     = cppr_q;
    pprio_n    = pprio_q;
    mfrr_n     = mfrr_q;
    xisr_n     = xisr_q;
    rej_n      = 1'b0;
    rej_src_n  = rej_src_q;
    resend_n   = 1'b0;
    eoi_n      = 1'b0;
    eoi_src_n  = eoi_src_q;
    rsp_n      = 1'b0;
    rsp_data_n = rsp_data_q;
    rsp_mfrr_n = rsp_mfrr_q;
    if (cmd_valid) begin
      case (op)
        OP_POLL: begin
          rsp_n      = 1'b1;
          rsp_data_n = {cppr_q, xisr_q};
          rsp_mfrr_n = mfrr_q;
        end
        OP_ACCEPT: begin
          rsp_n      = 1'b1;
          rsp_data_n = {cppr_q, xisr_q};
          rsp_mfrr_n = mfrr_q;
          cppr_n     = pprio_q;
          xisr_n     = '0;
          pprio_n    = PRIO_NONE;
        end
        OP_CPPR: begin
          cppr_n = op_prio;
          if (op_prio < cppr_q) begin
            if (held_any && (op_prio <= pprio_q)) begin
              xisr_n    = '0;
              pprio_n   = PRIO_NONE;
              rej_n     = bounce;
              rej_src_n = bounce ? xisr_q : rej_src_q;
            end
          end else if (!held_any) begin
            resend_n = 1'b1;
            if (mfrr_q < op_prio) begin
              xisr_n  = IPI_NUM;
              pprio_n = mfrr_q;
            end
          end
        end
        OP_MFRR: begin
          mfrr_n = op_prio;
          if ((op_prio < cppr_q) && ipi_take) begin
            rej_n     = bounce;
            rej_src_n = bounce ? xisr_q : rej_src_q;
            xisr_n    = IPI_NUM;
            pprio_n   = op_prio;
          end
        end
        OP_EOI: begin
          cppr_n    = eoi_prio;
          eoi_n     = 1'b1;
          eoi_src_n = cmd_data[SRC_W-1:0];
          if (!held_any) begin
            resend_n = 1'b1;
            if (mfrr_q < eoi_prio) begin
              xisr_n  = IPI_NUM;
              pprio_n = mfrr_q;
            end
          end
        end
        default: ;
      endcase
    end else if (ofr_valid) begin
      if (ofr_take) begin
        rej_n     = bounce;
        rej_src_n = bounce ? xisr_q : rej_src_q;
        xisr_n    = ofr_src;
        pprio_n   = ofr_prio;
      end else begin
        rej_n     = 1'b1;
        rej_src_n = ofr_src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q     <= '0;
      pprio_q    <= PRIO_NONE;
      mfrr_q     <= PRIO_NONE;
      xisr_q     <= '0;
      irq_q      <= 1'b0;
      rej_q      <= 1'b0;
      rej_src_q  <= '0;
      resend_q   <= 1'b0;
      eoi_q      <= 1'b0;
      eoi_src_q  <= '0;
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
      rsp_mfrr_q <= '0;
    end else begin
      cppr_q     <= cppr_n;
      pprio_q    <= pprio_n;
      mfrr_q     <= mfrr_n;
      xisr_q     <= xisr_n;
      irq_q      <= (xisr_n != '0);
      rej_q      <= rej_n;
      rej_src_q  <= rej_src_n;
      resend_q   <= resend_n;
      eoi_q      <= eoi_n;
      eoi_src_q  <= eoi_src_n;
      rsp_q      <= rsp_n;
      rsp_data_q <= rsp_data_n;
      rsp_mfrr_q <= rsp_mfrr_n;
    end
  end

  assign irq_out    = irq_q;
  assign rej_valid  = rej_q;
  assign rej_src    = rej_src_q;
  assign resend_req = resend_q;
  assign eoi_valid  = eoi_q;
  assign eoi_src    = eoi_src_q;
  assign rsp_valid  = rsp_q;
  assign rsp_data   = rsp_data_q;
  assign rsp_mfrr   = rsp_mfrr_q;
endmodule

// File: rtl/intr_present_unit_chk.sv
module intr_present_unit_chk #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic [PRIO_W+SRC_W-1:0] cmd_data,
  input logic                    irq_out,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    rsp_valid,
  input logic [SRC_W-1:0]        xisr_q,
  input logic [PRIO_W-1:0]       pprio_q,
  input logic [PRIO_W-1:0]       cppr_q,
  input logic [PRIO_W-1:0]       mfrr_q
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  AST_IRQ_TRACKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0)); // R12

  AST_EMPTY_SLOT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (xisr_q == '0) |-> (pprio_q == '1)); // R7

  AST_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> (!irq_out && rsp_valid)); // R7

  AST_POLL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> ($stable(cppr_q) && $stable(xisr_q)
      && $stable(pprio_q) && $stable(mfrr_q) && rsp_valid)); // R10

  AST_EOI_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0]))); // R8

  AST_IPI_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != IPI_NUM)); // R11
endmodule

bind intr_present_unit intr_present_unit_chk #(
  .SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .irq_out(irq_out), .rej_valid(rej_valid),
  .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
  .rsp_valid(rsp_valid), .xisr_q(xisr_q), .pprio_q(pprio_q),
  .cppr_q(cppr_q), .mfrr_q(mfrr_q)
);

// File: tb/intr_present_unit_tb.sv
module intr_present_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        ofr_valid = 1'b0;
  logic        ofr_ready;
  logic [23:0] ofr_src = '0;
  logic [7:0]  ofr_prio = '0;
  logic        irq_out, rej_valid, resend_req, eoi_valid, rsp_valid;
  logic [23:0] rej_src, eoi_src;
  logic [31:0] rsp_data;
  logic [7:0]  rsp_mfrr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_present_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .ofr_valid(ofr_valid), .ofr_ready(ofr_ready),
    .ofr_src(ofr_src), .ofr_prio(ofr_prio), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_mfrr(rsp_mfrr)
  );

  // {req, is_offer, op, data, prio, irq, rej, rej_src, resend, rsp, rsp_data, eoi}
  typedef struct packed {
    logic [3:0]  req;
    logic        is_ofr;
    logic [2:0]  op;
    logic [31:0] data;
    logic [7:0]  prio;
    logic        e_irq;
    logic        e_rej;
    logic [23:0] e_rej_src;
    logic        e_resend;
    logic        e_rsp;
    logic [31:0] e_rsp_data;
    logic        e_eoi;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    // R2: threshold 0 rejects everything
    '{4'd2, 1'b1, 3'd0, 32'h10, 8'h05, 1'b0, 1'b1, 24'h10, 1'b0, 1'b0, 32'h0, 1'b0},
    // R6: less favored write with empty slot resends
    '{4'd6, 1'b0, 3'd2, 32'hff, 8'h00, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 32'h0, 1'b0},
    // R3: offer taken
    '{4'd3, 1'b1, 3'd0, 32'h10, 8'h05, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0, 1'b0},
    // R2: equal priority to pending is rejected
    '{4'd2, 1'b1, 3'd0, 32'h20, 8'h05, 1'b1, 1'b1, 24'h20, 1'b0, 1'b0, 32'h0, 1'b0},
    // R3: better offer displaces 0x10
    '{4'd3, 1'b1, 3'd0, 32'h30, 8'h03, 1'b1, 1'b1, 24'h10, 1'b0, 1'b0, 32'h0, 1'b0},
    // R10: poll
    '{4'd10, 1'b0, 3'd0, 32'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b1, 32'hff000030, 1'b0},
    // R7: accept
    '{4'd7, 1'b0, 3'd1, 32'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 32'hff000030, 1'b0},
    // R2: offer equal to threshold 3 rejected
    '{4'd2, 1'b1, 3'd0, 32'h40, 8'h03, 1'b0, 1'b1, 24'h40, 1'b0, 1'b0, 32'h0, 1'b0},
    // R3: offer prio 1 taken
    '{4'd3, 1'b1, 3'd0, 32'h40, 8'h01, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0, 1'b0},
    // R4: IPI at 2 loses to pending prio 1
    '{4'd4, 1'b0, 3'd3, 32'h02, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0, 1'b0},
    // R4: IPI at 0 displaces 0x40
    '{4'd4, 1'b0, 3'd3, 32'h00, 8'h00, 1'b1, 1'b1, 24'h40, 1'b0, 1'b0, 32'h0, 1'b0},
    // R10: poll shows IPI pending
    '{4'd10, 1'b0, 3'd0, 32'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b1, 32'h03000002, 1'b0},
    // R5 R11: favored write drops IPI, no reject
    '{4'd11, 1'b0, 3'd2, 32'h00, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0, 1'b0},
    // R8 R9: EOI with empty slot resends and injects IPI
    '{4'd9, 1'b0, 3'd4, 32'h05000040, 8'h00, 1'b1, 1'b0, 24'h0, 1'b1, 1'b0, 32'h0, 1'b1},
    // R7: accept IPI
    '{4'd7, 1'b0, 3'd1, 32'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 32'h05000002, 1'b0},
    // R4: IPI priority ff not below threshold 0
    '{4'd4, 1'b0, 3'd3, 32'hff, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0, 1'b0},
    // R8: EOI resends, no IPI injected
    '{4'd8, 1'b0, 3'd4, 32'hff000002, 8'h00, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 32'h0, 1'b1}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit cv, input logic [2:0] op, input logic [31:0] d,
                      input bit ov, input logic [23:0] src, input logic [7:0] pr);
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    ofr_valid = ov; ofr_src = src; ofr_prio = pr;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; ofr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports, then via poll
    chk(!irq_out && !rej_valid && !resend_req && !eoi_valid && !rsp_valid, 1,
        "idle outputs after reset", {27'b0, irq_out, rej_valid, resend_req, eoi_valid, rsp_valid}, 32'h0);
    step(1'b1, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    chk(rsp_valid && rsp_data == 32'h0, 1, "reset word", rsp_data, 32'h0);
    chk(rsp_mfrr == 8'hff, 1, "reset ipi prio", {24'h0, rsp_mfrr}, 32'hff);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      step(!v.is_ofr, v.op, v.data, v.is_ofr, v.data[23:0], v.prio);
      chk(irq_out == v.e_irq, v.req, $sformatf("vec %0d irq", i), {31'h0, irq_out}, {31'h0, v.e_irq});
      chk(rej_valid == v.e_rej && (!v.e_rej || rej_src == v.e_rej_src), v.req,
          $sformatf("vec %0d reject", i), {7'h0, rej_valid, rej_src}, {7'h0, v.e_rej, v.e_rej_src});
      chk(resend_req == v.e_resend, v.req, $sformatf("vec %0d resend", i),
          {31'h0, resend_req}, {31'h0, v.e_resend});
      chk(rsp_valid == v.e_rsp && (!v.e_rsp || rsp_data == v.e_rsp_data), v.req,
          $sformatf("vec %0d response", i), rsp_data, v.e_rsp_data);
      chk(eoi_valid == v.e_eoi && (!v.e_eoi || eoi_src == v.data[23:0]), v.req,
          $sformatf("vec %0d eoi", i), {7'h0, eoi_valid, eoi_src}, {7'h0, v.e_eoi, v.data[23:0]});
    end

    // R12: offer blocked while a command is presented; state threshold ff, empty
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; ofr_valid = 1'b1; ofr_src = 24'h50; ofr_prio = 8'h01;
    #1;
    chk(!ofr_ready, 12, "ready with command", {31'h0, ofr_ready}, 32'h0);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; ofr_valid = 1'b0;
    chk(!rej_valid && !irq_out, 12, "blocked offer no effect", {30'h0, rej_valid, irq_out}, 32'h0);
    step(1'b1, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    chk(rsp_data == 32'hff000000, 12, "slot still empty", rsp_data, 32'hff000000);

    // R5: favored write above pending priority keeps it
    step(1'b0, 3'd0, 32'h0, 1'b1, 24'h60, 8'h04);
    step(1'b1, 3'd2, 32'h10, 1'b0, 24'h0, 8'h0);
    chk(irq_out && !rej_valid, 5, "pending kept", {30'h0, irq_out, rej_valid}, 32'h2);
    // R6: less favored write while pending gives no resend
    step(1'b1, 3'd2, 32'h20, 1'b0, 24'h0, 8'h0);
    chk(!resend_req && irq_out, 6, "no resend while pending", {30'h0, resend_req, irq_out}, 32'h1);
    step(1'b1, 3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    chk(rsp_data == 32'h20000060, 5, "word after writes", rsp_data, 32'h20000060);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule